// File: doc/BRIEF.md
# DMA Register File and Interrupt Status Unit

This block is the software-facing register front end of a ten-channel DMA controller. A single register bus carries a 32-bit byte address, a read strobe, a write strobe and 32-bit write data. The block decodes the address into a channel and a register slot. It stores every per-channel register and the three global registers: control, status and enable. It returns read data one cycle after the strobe. The transfer engines are outside this block. They receive the channel control, memory address, quadword count and tag address words together with a hold-off level, and they report finished transfers through one done pulse per channel.

The status register packs two kinds of bit into one word. Per-channel completion flags are set by hardware and cleared by software writing ones. Per-channel mask bits are inverted by software writing ones. A single interrupt line is high while any channel has both its flag and its mask bit set. Channels sit at a sparse, irregular set of address codes. Any access that falls outside the defined map reads as zero, changes nothing and raises a one-cycle error pulse.

Top module: `xfer_csr_unit`

## Requirements
- R1: Address bits [15:8] select the channel. The codes 0x80, 0x90, 0xA0, 0xB0, 0xB4, 0xC0, 0xC4, 0xC8, 0xD0 and 0xD4 select channels 0 to 9. Address bits [7:4] select the slot: 0 control, 1 memory address, 2 quadword count, 3 tag address, 4 and 5 address stack, 8 stall address. Each slot reads back the value last written to it.
- R2: A write to the memory address slot stores the write data ANDed with 0x01FFFFF0.
- R3: Code 0xE0 is the global block: offset 0 is global control and offset 1 is status. Status reads return the flags in bits [9:0] and the mask in bits [25:16], all other bits zero. On a status write, a 1 in data bit n (n below 10) clears flag n, a 1 in data bit 16+n inverts mask bit n, and data bits [15:10] and [31:26] have no effect.
- R4: A done pulse on channel n sets flag n at the next clock edge. If the same edge also carries a software clear of flag n, the flag stays set.
- R5: `irq` is high exactly while flags AND mask is nonzero. It therefore reflects a status write or a done pulse from the cycle after it.
- R6: The enable register is written at code 0xF5 offset 9 and read at code 0xF5 offset 2. Its bit 16 drives `hold_off`.
- R7: The following accesses read as zero, are ignored on write, and set `acc_err` high for the one cycle after the access: address bits [31:16] other than 0x1000, nonzero bits [3:0], an unknown code, an undefined offset, a read of the enable write address, and a write to the enable read address.
- R8: A read sets `rd_valid` and `rd_data` in the cycle after the strobe. Reads change no register, including status.
- R9: After reset, all registers are zero and `irq` and `hold_off` are low.
- R10: The channel output buses carry each channel's control, memory address, count and tag slots from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| acc_err | output | 1 | One-cycle pulse after an undefined access |
| done_pulse | input | 10 | Per-channel transfer-finished pulses |
| ch_ctrl | output | 320 | Control slot of each channel, channel n at [32n+31:32n] |
| ch_maddr | output | 320 | Memory address slot of each channel |
| ch_count | output | 320 | Quadword count slot of each channel |
| ch_tag | output | 320 | Tag address slot of each channel |
| glb_ctrl | output | 32 | Global control register |
| hold_off | output | 1 | Enable register bit 16 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together. They also assume that `done_pulse` bits are single-cycle events that may coincide with status writes. The bench drives the two strobes only from separate tasks, one access at a time. It raises done pulses alone or in the same cycle as a status write, which reaches the set-versus-clear corner. Read results are matched in order against a queue of values computed from the requirement text.

// File: rtl/xfer_csr_pkg.sv
`timescale 1ns/1ps
package xfer_csr_pkg;
   // slot numbers inside a channel bank
   localparam int unsigned SL_CTRL  = 0;
   localparam int unsigned SL_MADDR = 1;
   localparam int unsigned SL_COUNT = 2;
   localparam int unsigned SL_TAG   = 3;
   localparam int unsigned SL_STK0  = 4;
   localparam int unsigned SL_STK1  = 5;
   localparam int unsigned SL_STALL = 6;
   localparam int unsigned NSLOT    = 7;

   localparam logic [15:0] BASE_HI  = 16'h1000;
   localparam logic [7:0]  GLB_CODE = 8'hE0;
   localparam logic [7:0]  ENA_CODE = 8'hF5;
   localparam logic [3:0]  EOFF_RD  = 4'h2;
   localparam logic [3:0]  EOFF_WR  = 4'h9;

   typedef enum logic [2:0] {
      TGT_NONE, TGT_CHAN, TGT_GCTRL, TGT_STAT, TGT_ENA_RD, TGT_ENA_WR
   } tgt_e;

   typedef struct packed {
      tgt_e       tgt;
      logic [3:0] chan;
      logic [2:0] slot;
   } dec_s;
endpackage

// File: rtl/xfer_addr_decode.sv
`timescale 1ns/1ps
module xfer_addr_decode
   import xfer_csr_pkg::*;
#(
   parameter int unsigned NCH = 10,
   parameter logic [NCH*8-1:0] CHAN_CODES = '0
) (
   input  logic [31:0]    addr,
   output logic [NCH-1:0] chan_hit,
   output dec_s           dec
);
   logic [7:0] code;
   logic [3:0] off;
   logic       frame_ok;

   assign code     = addr[15:8];
   assign off      = addr[7:4];
   assign frame_ok = (addr[31:16] == BASE_HI) && (addr[3:0] == 4'h0);

   for (genvar i = 0; i < NCH; i++) begin : g_hit
      assign chan_hit[i] = frame_ok && (code == CHAN_CODES[i*8 +: 8]);
   end

   always_comb begin
      dec = '{tgt: TGT_NONE, chan: 4'h0, slot: 3'h0};
      if (|chan_hit) begin
         for (int i = 0; i < NCH; i++)
            if (chan_hit[i]) dec.chan = 4'(i);
         dec.tgt = TGT_CHAN;
         case (off)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: dec.slot = off[2:0];
            4'h8:    dec.slot = 3'(SL_STALL);
            default: dec.tgt = TGT_NONE;
         endcase
      end else if (frame_ok && code == GLB_CODE) begin
         if (off == 4'h0)      dec.tgt = TGT_GCTRL;
         else if (off == 4'h1) dec.tgt = TGT_STAT;
      end else if (frame_ok && code == ENA_CODE) begin
         if (off == EOFF_RD)      dec.tgt = TGT_ENA_RD;
         else if (off == EOFF_WR) dec.tgt = TGT_ENA_WR;
      end
   end
endmodule

// File: rtl/xfer_chan_bank.sv
`timescale 1ns/1ps
module xfer_chan_bank
   import xfer_csr_pkg::*;
#(
   parameter int unsigned NCH = 10,
   parameter int unsigned DW  = 32,
   parameter logic [DW-1:0] MADDR_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        sel_chan,
   input  logic [2:0]        sel_slot,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rd_word,
   output logic [NCH*DW-1:0] ctrl_o,
   output logic [NCH*DW-1:0] maddr_o,
   output logic [NCH*DW-1:0] count_o,
   output logic [NCH*DW-1:0] tag_o
);
   logic [DW-1:0] bank_q [NCH][NSLOT];

   function automatic logic [DW-1:0] slot_mask(int unsigned s);
      return (s == SL_MADDR) ? MADDR_MASK : '1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++)
            for (int s = 0; s < NSLOT; s++) bank_q[i][s] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NCH; i++)
            for (int s = 0; s < NSLOT; s++)
               if (sel_chan == 4'(i) && sel_slot == 3'(s))
                  bank_q[i][s] <= wdata & slot_mask(s);
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NCH; i++)
         for (int s = 0; s < NSLOT; s++)
            if (sel_chan == 4'(i) && sel_slot == 3'(s)) rd_word = bank_q[i][s];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_out
      assign ctrl_o [i*DW +: DW] = bank_q[i][SL_CTRL];
      assign maddr_o[i*DW +: DW] = bank_q[i][SL_MADDR];
      assign count_o[i*DW +: DW] = bank_q[i][SL_COUNT];
      assign tag_o  [i*DW +: DW] = bank_q[i][SL_TAG];

      // R2: stored address is the masked write data
      a_r2_maddr_masked: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && sel_chan == 4'(i) && sel_slot == 3'(SL_MADDR))
         |=> (maddr_o[i*DW +: DW] == ($past(wdata) & MADDR_MASK)));
   end
endmodule

// File: rtl/xfer_irq_status.sv
`timescale 1ns/1ps
module xfer_irq_status #(
   parameter int unsigned NCH = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stat_wr,
   input  logic [NCH-1:0] clr_bits,
   input  logic [NCH-1:0] tgl_bits,
   input  logic [NCH-1:0] done_i,
   output logic [NCH-1:0] flags_o,
   output logic [NCH-1:0] mask_o,
   output logic           irq_o
);
   logic [NCH-1:0] clr_eff, tgl_eff;

   assign clr_eff = stat_wr ? clr_bits : '0;
   assign tgl_eff = stat_wr ? tgl_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_o <= '0;
         mask_o  <= '0;
      end else begin
         flags_o <= (flags_o & ~clr_eff) | done_i;   // hardware set wins
         mask_o  <= mask_o ^ tgl_eff;
      end
   end

   assign irq_o = |(flags_o & mask_o);

   // R4: every done pulse leaves its flag set
   a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_i) |=> ((flags_o & $past(done_i)) == $past(done_i)));
   // R3: cleared flags are gone unless hardware set them in the same cycle
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((flags_o & $past(clr_bits) & ~$past(done_i)) == '0));
   // R3: mask inverts on write
   a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> (mask_o == ($past(mask_o) ^ $past(tgl_bits))));
   a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> $stable(mask_o));
   // R5: interrupt changes only after a status write or a done pulse
   a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(stat_wr) || (|$past(done_i))));
   a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(stat_wr));
endmodule

// File: rtl/xfer_csr_unit.sv
`timescale 1ns/1ps
module xfer_csr_unit
   import xfer_csr_pkg::*;
#(
   parameter int unsigned NCH = 10,
   parameter int unsigned DW  = 32,
   parameter logic [NCH*8-1:0] CHAN_CODES = 80'hD4_D0_C8_C4_C0_B4_B0_A0_90_80,
   parameter logic [DW-1:0] MADDR_MASK = 32'h01FF_FFF0,
   parameter int unsigned HOLD_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     rd_data,
   output logic              rd_valid,
   output logic              acc_err,
   input  logic [NCH-1:0]    done_pulse,
   output logic [NCH*DW-1:0] ch_ctrl,
   output logic [NCH*DW-1:0] ch_maddr,
   output logic [NCH*DW-1:0] ch_count,
   output logic [NCH*DW-1:0] ch_tag,
   output logic [DW-1:0]     glb_ctrl,
   output logic              hold_off,
   output logic              irq
);
   localparam int unsigned MASK_LSB = 16;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("NCH must be between 1 and 16");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32 for the status layout");
   end
   if (HOLD_BIT >= DW) begin : g_bad_hold
      $error("HOLD_BIT out of range");
   end

   dec_s           dec;
   logic [NCH-1:0] chan_hit;
   logic [DW-1:0]  bank_word, ena_q, mux_word, stat_word;
   logic [NCH-1:0] flags, mask;
   logic           access, illegal, stat_wr;

   xfer_addr_decode #(.NCH(NCH), .CHAN_CODES(CHAN_CODES)) u_dec (
      .addr(bus_addr), .chan_hit(chan_hit), .dec(dec));

   xfer_chan_bank #(.NCH(NCH), .DW(DW), .MADDR_MASK(MADDR_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && dec.tgt == TGT_CHAN),
      .sel_chan(dec.chan), .sel_slot(dec.slot), .wdata(bus_wdata),
      .rd_word(bank_word), .ctrl_o(ch_ctrl), .maddr_o(ch_maddr),
      .count_o(ch_count), .tag_o(ch_tag));

   assign stat_wr = bus_wr && dec.tgt == TGT_STAT;

   xfer_irq_status #(.NCH(NCH)) u_stat (
      .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr),
      .clr_bits(bus_wdata[NCH-1:0]), .tgl_bits(bus_wdata[MASK_LSB +: NCH]),
      .done_i(done_pulse), .flags_o(flags), .mask_o(mask), .irq_o(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_ctrl <= '0;
         ena_q    <= '0;
      end else if (bus_wr) begin
         if (dec.tgt == TGT_GCTRL)  glb_ctrl <= bus_wdata;
         if (dec.tgt == TGT_ENA_WR) ena_q    <= bus_wdata;
      end
   end
   assign hold_off = ena_q[HOLD_BIT];

   always_comb begin
      stat_word = '0;
      stat_word[NCH-1:0]         = flags;
      stat_word[MASK_LSB +: NCH] = mask;
      case (dec.tgt)
         TGT_CHAN:   mux_word = bank_word;
         TGT_GCTRL:  mux_word = glb_ctrl;
         TGT_STAT:   mux_word = stat_word;
         TGT_ENA_RD: mux_word = ena_q;
         default:    mux_word = '0;
      endcase
   end

   assign access  = bus_rd || bus_wr;
   assign illegal = (dec.tgt == TGT_NONE)
                 || (bus_rd && dec.tgt == TGT_ENA_WR)
                 || (bus_wr && dec.tgt == TGT_ENA_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
         acc_err  <= 1'b0;
      end else begin
         rd_valid <= bus_rd;
         acc_err  <= access && illegal;
         if (bus_rd) rd_data <= mux_word;
      end
   end

   // R1: at most one channel code can match
   a_r1_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_hit));
   // R7: unmapped access pulses the error flag next cycle
   a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (access && dec.tgt == TGT_NONE) |=> acc_err);
   a_r7_err_rdzero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && dec.tgt == TGT_NONE) |=> (rd_data == '0));
   // R8: one cycle read latency
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> rd_valid);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !rd_valid);
   // R6: hold-off follows the written enable bit
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && dec.tgt == TGT_ENA_WR) |=> (hold_off == $past(bus_wdata[HOLD_BIT])));
endmodule

// File: tb/xfer_csr_unit_test.sv
`timescale 1ns/1ps
module xfer_csr_unit_test;
   localparam int NCH = 10;
   localparam logic [7:0] CODES [NCH] =
      '{8'h80, 8'h90, 8'hA0, 8'hB0, 8'hB4, 8'hC0, 8'hC4, 8'hC8, 8'hD0, 8'hD4};
   localparam logic [31:0] STAT = 32'h1000_E010;
   localparam logic [31:0] GCTL = 32'h1000_E000;
   localparam logic [31:0] ENRD = 32'h1000_F520;
   localparam logic [31:0] ENWR = 32'h1000_F590;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic bus_rd = 1'b0, bus_wr = 1'b0;
   logic [NCH-1:0] done_pulse = '0;
   logic [31:0] rd_data, glb_ctrl;
   logic rd_valid, acc_err, hold_off, irq;
   logic [NCH*32-1:0] ch_ctrl, ch_maddr, ch_count, ch_tag;

   int checks = 0, fails = 0;
   logic last_err;
   bit done_flag = 0;
   logic [31:0] exp_q [$];
   string tag_q [$];

   xfer_csr_unit uut (.*);

   always #10 clk = ~clk;

   function automatic logic [31:0] ca(int ch, int off);
      return 32'h1000_0000 | (32'(CODES[ch]) << 8) | (32'(off) << 4);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] a, logic [31:0] d, logic [NCH-1:0] dn = '0);
      @(posedge clk); #2;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; done_pulse = dn;
      @(posedge clk); #2;
      bus_wr = 1'b0; done_pulse = '0; last_err = acc_err;
   endtask

   task automatic rd(logic [31:0] a, logic [31:0] e, string req);
      exp_q.push_back(e); tag_q.push_back(req);
      @(posedge clk); #2;
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #2;
      bus_rd = 1'b0; last_err = acc_err;
   endtask

   task automatic pulse(logic [NCH-1:0] dn);
      @(posedge clk); #2; done_pulse = dn;
      @(posedge clk); #2; done_pulse = '0;
   endtask

   // monitor: pops expected read values as results appear
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk("R8 unexpected read", rd_data, 32'hxxxx_xxxx);
         else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #35 rst_n = 1'b1;
      #10;
      // R9 reset state
      chk("R9 irq", {31'b0, irq}, 32'h0);
      chk("R9 hold_off", {31'b0, hold_off}, 32'h0);
      rd(ca(0, 0), 32'h0, "R9 ctrl reset");
      rd(STAT, 32'h0, "R9 status reset");

      // R1/R10 every channel code and the four exported slots
      for (int i = 0; i < NCH; i++) begin
         wr(ca(i, 0), 32'hC000_0000 | i);
         wr(ca(i, 2), 32'h0000_0100 + i);
         wr(ca(i, 3), 32'h0002_0000 + 16 * i);
         chk("R10 ctrl out", ch_ctrl[i*32 +: 32], 32'hC000_0000 | i);
         chk("R10 count out", ch_count[i*32 +: 32], 32'h0000_0100 + i);
         chk("R10 tag out", ch_tag[i*32 +: 32], 32'h0002_0000 + 16 * i);
         rd(ca(i, 0), 32'hC000_0000 | i, "R1 ctrl readback");
      end
      wr(ca(4, 4), 32'h1111_2222);
      wr(ca(4, 5), 32'h3333_4444);
      wr(ca(4, 8), 32'h5555_6666);
      rd(ca(4, 4), 32'h1111_2222, "R1 stack0");
      rd(ca(4, 5), 32'h3333_4444, "R1 stack1");
      rd(ca(4, 8), 32'h5555_6666, "R1 stall");
      rd(ca(5, 2), 32'h0000_0105, "R1 count readback");

      // R2 memory address masking
      wr(ca(3, 1), 32'hFFFF_FFFF);
      chk("R2 maddr out", ch_maddr[3*32 +: 32], 32'h01FF_FFF0);
      rd(ca(3, 1), 32'h01FF_FFF0, "R2 maddr readback");
      wr(ca(9, 1), 32'h0123_4567);
      rd(ca(9, 1), 32'h0123_4560, "R2 maddr low bits");

      // R7 undefined accesses
      wr(32'h1000_8500, 32'hDEAD_BEEF);
      chk("R7 bad code err", {31'b0, last_err}, 32'h1);
      rd(ca(0, 6), 32'h0, "R7 bad offset reads zero");
      chk("R7 bad offset err", {31'b0, last_err}, 32'h1);
      wr(32'h1000_8004, 32'hDEAD_BEEF);
      chk("R7 low bits err", {31'b0, last_err}, 32'h1);
      wr(32'h2000_8000, 32'hDEAD_BEEF);
      chk("R7 base err", {31'b0, last_err}, 32'h1);
      rd(ca(0, 0), 32'hC000_0000, "R7 ignored writes");
      chk("R7 good access no err", {31'b0, last_err}, 32'h0);
      wr(32'h1000_E030, 32'h1234_5678);
      chk("R7 global offset err", {31'b0, last_err}, 32'h1);

      // R4 / R5 / R3 status behaviour
      pulse(10'h084);
      chk("R5 masked off", {31'b0, irq}, 32'h0);
      rd(STAT, 32'h0000_0084, "R4 flags set");
      wr(STAT, 32'h0004_0000);
      chk("R5 irq on after toggle", {31'b0, irq}, 32'h1);
      rd(STAT, 32'h0004_0084, "R3 mask toggled");
      wr(STAT, 32'h0084_0000);
      chk("R5 irq via ch7", {31'b0, irq}, 32'h1);
      wr(STAT, 32'h0000_0080);
      chk("R5 irq off after clear", {31'b0, irq}, 32'h0);
      rd(STAT, 32'h0080_0004, "R3 clear and toggle");
      wr(STAT, 32'h0000_0004, 10'h004);
      rd(STAT, 32'h0080_0004, "R4 set beats clear");
      wr(STAT, 32'hFC00_FC00);
      rd(STAT, 32'h0080_0004, "R3 unused bits no effect");
      pulse(10'h080);
      chk("R5 irq from done", {31'b0, irq}, 32'h1);
      rd(STAT, 32'h0080_0084, "R8 status read");
      rd(STAT, 32'h0080_0084, "R8 read has no side effect");

      // R6 enable register
      wr(ENWR, 32'h0001_0000);
      chk("R6 hold_off set", {31'b0, hold_off}, 32'h1);
      rd(ENRD, 32'h0001_0000, "R6 enable readback");
      rd(ENWR, 32'h0, "R7 enable write addr reads zero");
      chk("R7 enable write addr err", {31'b0, last_err}, 32'h1);
      wr(ENRD, 32'h0);
      chk("R7 enable read addr err", {31'b0, last_err}, 32'h1);
      chk("R6 hold_off kept", {31'b0, hold_off}, 32'h1);
      wr(ENWR, 32'h0);
      chk("R6 hold_off clear", {31'b0, hold_off}, 32'h0);

      // R3 global control
      wr(GCTL, 32'hA5A5_0001);
      chk("R3 global ctrl out", glb_ctrl, 32'hA5A5_0001);
      rd(GCTL, 32'hA5A5_0001, "R3 global ctrl readback");

      repeat (3) @(posedge clk);
      #2;
      chk("R8 all reads returned", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule